// File: doc/BRIEF.md
# Boot Overlay Memory Bank Controller

This block steers every CPU memory cycle in a 64 KB address space to either a boot ROM or a 64 KB RAM. The space is divided into eight 8 KB windows selected by the top three address bits. After reset the controller first zeroes the whole RAM with an internal counter and holds the CPU off with a busy output. It then enters a boot overlay in which every read, whatever the window, is served by ROM. Writes still land in RAM at the CPU address, so software can fill RAM that ROM is hiding.

The first I/O write of any kind ends the overlay. From that point reads of windows 0 to 6 come from RAM at the CPU address. The top window (0xE000 to 0xFFFF) reads ROM or RAM depending on a mapping flag. That flag is loaded from data bit 0 whenever the CPU writes the control register of the on-board parallel port. The port decodes the register and reports the write on a strobe input. While the overlay is active, every I/O read returns 0xFF.

Top module: `boot_overlay_bank`

## Requirements
- R1: While rst_ni is low and right after it rises, the overlay flag and the mapping flag are both 1 and busy_o is 1.
- R2: After reset, busy_o stays high for exactly 65536 cycles. In cycle k of that run the block asserts ram_sel_o and ram_we_o, drives ram_addr_o = k and ram_wdata_o = 0, and keeps rom_sel_o low. CPU strobes and I/O strobes seen while busy_o is high have no effect.
- R3: While the overlay is active, a read (rd_i=1, wr_i=0) in any of the eight windows asserts rom_sel_o only, with rom_off_o = addr_i[12:0].
- R4: While the overlay is active, a write asserts ram_sel_o and ram_we_o with ram_addr_o = addr_i and ram_wdata_o = data_i.
- R5: An I/O write (io_wr_i=1 while not busy) ends the overlay, and reads decode in normal mode from the next cycle on.
- R6: io_rdata_o is 0xFF while the overlay is active and equals io_rdata_i afterwards.
- R7: In normal mode, a read of windows 0 to 6 asserts ram_sel_o only, with ram_addr_o = addr_i.
- R8: In normal mode, a read of window 7 asserts rom_sel_o when the mapping flag is 1. When the flag is 0 it asserts ram_sel_o with ram_addr_o = addr_i.
- R9: A cycle with ctl_wr_i=1 and io_wr_i=1 while not busy loads data_i[0] into the mapping flag, effective from the next cycle. ctl_wr_i without io_wr_i changes nothing.
- R10: In normal mode, writes go to RAM at addr_i whatever the mapping flag holds. A write takes priority over a read asserted in the same cycle.
- R11: rom_sel_o and ram_sel_o are never high together. With no strobe and not busy, both selects and ram_we_o are 0, and ram_addr_o, rom_off_o and ram_wdata_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU memory address |
| rd_i | input | 1 | CPU memory read strobe |
| wr_i | input | 1 | CPU memory write strobe |
| data_i | input | 8 | CPU write data (bit 0 also feeds the mapping flag) |
| io_wr_i | input | 1 | CPU I/O write strobe, any port |
| ctl_wr_i | input | 1 | Parallel-port control register write detect |
| io_rdata_i | input | 8 | Read data from the I/O peripherals |
| busy_o | output | 1 | RAM clear in progress, CPU must wait |
| rom_sel_o | output | 1 | Cycle goes to ROM |
| rom_off_o | output | 13 | ROM byte offset |
| ram_sel_o | output | 1 | Cycle goes to RAM |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 16 | Physical RAM address |
| ram_wdata_o | output | 8 | RAM write data |
| io_rdata_o | output | 8 | I/O read data returned to the CPU |

## Verification
The assertions check the following on every cycle:
- the two selects never overlap;
- the clear run writes zero to consecutive addresses and refuses CPU writes;
- writes always reach RAM at the CPU address;
- overlay reads always hit ROM;
- I/O reads under the overlay return 0xFF;
- an I/O write drops the overlay;
- a qualified control write loads the flag;
- both flags hold still while busy.

Other behaviours show only in the bench's scenarios, where a reference model is compared on every clock. These are the exact length of the clear run, the point where the overlay switches off, and the top window changing between ROM and RAM over a sequence of control writes, including a strobe that arrives without io_wr_i.

// File: rtl/boot_bank_pkg.sv
package boot_bank_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_CLEAR,
    CYC_WRITE,
    CYC_READ
  } cyc_e;

  localparam logic [7:0] IO_FLOAT = 8'hFF;
endpackage

// File: rtl/boot_clr_seq.sv
module boot_clr_seq #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] cnt_q;
  logic              act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (act_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (&cnt_q) act_q <= 1'b0;
    end
  end

  assign busy_o = act_q;
  assign addr_o = cnt_q;
endmodule

// File: rtl/boot_mode_regs.sv
module boot_mode_regs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic io_wr_i,
  input  logic ctl_wr_i,
  input  logic ctl_bit_i,
  output logic startup_o,
  output logic top_map_o
);
  logic startup_q, top_map_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      startup_q <= 1'b1;
      top_map_q <= 1'b1;
    end else if (en_i && io_wr_i) begin
      startup_q <= 1'b0;
      if (ctl_wr_i) top_map_q <= ctl_bit_i;
    end
  end

  assign startup_o = startup_q;
  assign top_map_o = top_map_q;
endmodule

// File: rtl/boot_bank_dec.sv
module boot_bank_dec
  import boot_bank_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_BITS = 3,
  parameter int DATA_W   = 8
) (
  input  logic                     startup_i,
  input  logic                     top_map_i,
  input  logic                     busy_i,
  input  logic [ADDR_W-1:0]        clr_addr_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     rd_i,
  input  logic                     wr_i,
  input  logic [DATA_W-1:0]        data_i,
  input  logic [7:0]               io_rdata_i,
  output logic                     rom_sel_o,
  output logic [ADDR_W-WIN_BITS-1:0] rom_off_o,
  output logic                     ram_sel_o,
  output logic                     ram_we_o,
  output logic [ADDR_W-1:0]        ram_addr_o,
  output logic [DATA_W-1:0]        ram_wdata_o,
  output logic [7:0]               io_rdata_o
);
  localparam int NWIN  = 1 << WIN_BITS;
  localparam int OFF_W = ADDR_W - WIN_BITS;

  logic [NWIN-1:0]     win_rom;
  logic [WIN_BITS-1:0] win;
  cyc_e                cyc;

  assign win = addr_i[ADDR_W-1 -: WIN_BITS];

  // per-window read source: ROM under overlay, top window also by flag
  for (genvar w = 0; w < NWIN; w++) begin : g_win
    if (w == NWIN - 1) begin : g_top
      assign win_rom[w] = startup_i | top_map_i;
    end else begin : g_low
      assign win_rom[w] = startup_i;
    end
  end

  always_comb begin
    if (busy_i)    cyc = CYC_CLEAR;
    else if (wr_i) cyc = CYC_WRITE;
    else if (rd_i) cyc = CYC_READ;
    else           cyc = CYC_IDLE;
  end

  always_comb begin
    rom_sel_o   = 1'b0;
    rom_off_o   = '0;
    ram_sel_o   = 1'b0;
    ram_we_o    = 1'b0;
    ram_addr_o  = '0;
    ram_wdata_o = '0;
    unique case (cyc)
      CYC_CLEAR: begin
        ram_sel_o  = 1'b1;
        ram_we_o   = 1'b1;
        ram_addr_o = clr_addr_i;
      end
      CYC_WRITE: begin
        ram_sel_o   = 1'b1;
        ram_we_o    = 1'b1;
        ram_addr_o  = addr_i;
        ram_wdata_o = data_i;
      end
      CYC_READ: begin
        if (win_rom[win]) begin
          rom_sel_o = 1'b1;
          rom_off_o = addr_i[OFF_W-1:0];
        end else begin
          ram_sel_o  = 1'b1;
          ram_addr_o = addr_i;
        end
      end
      default: ;
    endcase
  end

  assign io_rdata_o = startup_i ? IO_FLOAT : io_rdata_i;
endmodule

// File: rtl/boot_overlay_bank.sv
module boot_overlay_bank #(
  parameter int ADDR_W   = 16,
  parameter int WIN_BITS = 3,
  parameter int DATA_W   = 8,
  parameter int MAP_BIT  = 0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       rd_i,
  input  logic                       wr_i,
  input  logic [DATA_W-1:0]          data_i,
  input  logic                       io_wr_i,
  input  logic                       ctl_wr_i,
  input  logic [7:0]                 io_rdata_i,
  output logic                       busy_o,
  output logic                       rom_sel_o,
  output logic [ADDR_W-WIN_BITS-1:0] rom_off_o,
  output logic                       ram_sel_o,
  output logic                       ram_we_o,
  output logic [ADDR_W-1:0]          ram_addr_o,
  output logic [DATA_W-1:0]          ram_wdata_o,
  output logic [7:0]                 io_rdata_o
);
  logic [ADDR_W-1:0] clr_addr;
  logic              startup, top_map;

  boot_clr_seq #(.ADDR_W(ADDR_W)) u_clr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_o (busy_o),
    .addr_o (clr_addr)
  );

  boot_mode_regs u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (!busy_o),
    .io_wr_i   (io_wr_i),
    .ctl_wr_i  (ctl_wr_i),
    .ctl_bit_i (data_i[MAP_BIT]),
    .startup_o (startup),
    .top_map_o (top_map)
  );

  boot_bank_dec #(
    .ADDR_W   (ADDR_W),
    .WIN_BITS (WIN_BITS),
    .DATA_W   (DATA_W)
  ) u_dec (
    .startup_i   (startup),
    .top_map_i   (top_map),
    .busy_i      (busy_o),
    .clr_addr_i  (clr_addr),
    .addr_i      (addr_i),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .data_i      (data_i),
    .io_rdata_i  (io_rdata_i),
    .rom_sel_o   (rom_sel_o),
    .rom_off_o   (rom_off_o),
    .ram_sel_o   (ram_sel_o),
    .ram_we_o    (ram_we_o),
    .ram_addr_o  (ram_addr_o),
    .ram_wdata_o (ram_wdata_o),
    .io_rdata_o  (io_rdata_o)
  );
endmodule

// File: rtl/boot_overlay_bank_chk.sv
module boot_overlay_bank_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] data_i,
  input logic              io_wr_i,
  input logic              ctl_wr_i,
  input logic              busy_o,
  input logic              rom_sel_o,
  input logic              ram_sel_o,
  input logic              ram_we_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic [DATA_W-1:0] ram_wdata_o,
  input logic [7:0]        io_rdata_o,
  input logic              startup,
  input logic              top_map
);
  assert_sel_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rom_sel_o && ram_sel_o));

  assert_clr_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (ram_we_o && ram_sel_o && !rom_sel_o && ram_wdata_o == '0));

  assert_clr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && $past(rst_ni)) |-> ram_addr_o == $past(ram_addr_o) + 1'b1);

  assert_hold_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(startup) && $stable(top_map)));

  assert_boot_rd_rom_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (startup && !busy_o && rd_i && !wr_i) |-> (rom_sel_o && !ram_sel_o));

  assert_wr_ram_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && wr_i) |-> (ram_we_o && ram_addr_o == addr_i && ram_wdata_o == data_i));

  assert_io_ends_boot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && io_wr_i) |=> !startup);

  assert_io_float_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    startup |-> io_rdata_o == 8'hFF);

  assert_map_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && io_wr_i && ctl_wr_i) |=> top_map == $past(data_i[0]));
endmodule

bind boot_overlay_bank boot_overlay_bank_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .rd_i        (rd_i),
  .wr_i        (wr_i),
  .data_i      (data_i),
  .io_wr_i     (io_wr_i),
  .ctl_wr_i    (ctl_wr_i),
  .busy_o      (busy_o),
  .rom_sel_o   (rom_sel_o),
  .ram_sel_o   (ram_sel_o),
  .ram_we_o    (ram_we_o),
  .ram_addr_o  (ram_addr_o),
  .ram_wdata_o (ram_wdata_o),
  .io_rdata_o  (io_rdata_o),
  .startup     (startup),
  .top_map     (top_map)
);

// File: tb/boot_overlay_bank_tb.sv
`timescale 1ns/1ps
module boot_overlay_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0, io_wr = 1'b0, ctl_wr = 1'b0;
  logic [7:0]  data = '0, io_rdata = '0;
  logic        busy, rom_sel, ram_sel, ram_we;
  logic [12:0] rom_off;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata, io_rdata_out;

  int n_tests = 0, n_fail = 0;
  // reference model state
  bit m_start = 1, m_map = 1, m_busy = 1;
  int m_cnt = 0;

  always #10 clk = ~clk;

  boot_overlay_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .data_i(data), .io_wr_i(io_wr), .ctl_wr_i(ctl_wr), .io_rdata_i(io_rdata),
    .busy_o(busy), .rom_sel_o(rom_sel), .rom_off_o(rom_off), .ram_sel_o(ram_sel),
    .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata),
    .io_rdata_o(io_rdata_out)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_start = 1; m_map = 1; m_busy = 1; m_cnt = 0;
    end else if (m_busy) begin
      if (m_cnt == 65535) m_busy = 0;
      m_cnt = (m_cnt + 1) % 65536;
    end else if (io_wr) begin
      m_start = 0;
      if (ctl_wr) m_map = data[0];
    end
  end

  task automatic check(string tag);
    bit e_rom = 0, e_ram = 0, e_we = 0;
    int e_addr = 0, e_off = 0, e_wd = 0, e_io;
    if (m_busy) begin
      e_ram = 1; e_we = 1; e_addr = m_cnt;
    end else if (wr) begin
      e_ram = 1; e_we = 1; e_addr = addr; e_wd = data;
    end else if (rd) begin
      if (m_start || (addr >= 16'hE000 && m_map)) begin
        e_rom = 1; e_off = addr & 16'h1FFF;
      end else begin
        e_ram = 1; e_addr = addr;
      end
    end
    e_io = m_start ? 8'hFF : io_rdata;
    n_tests++;
    if (busy !== m_busy || rom_sel !== e_rom || ram_sel !== e_ram || ram_we !== e_we ||
        ram_addr !== 16'(e_addr) || rom_off !== 13'(e_off) || ram_wdata !== 8'(e_wd) ||
        io_rdata_out !== 8'(e_io)) begin
      n_fail++;
      $display("FAIL %s: got busy=%0b rom=%0b ram=%0b we=%0b addr=%h off=%h wd=%h io=%h exp busy=%0b rom=%0b ram=%0b we=%0b addr=%h off=%h wd=%h io=%h",
               tag, busy, rom_sel, ram_sel, ram_we, ram_addr, rom_off, ram_wdata, io_rdata_out,
               m_busy, e_rom, e_ram, e_we, 16'(e_addr), 13'(e_off), 8'(e_wd), 8'(e_io));
    end
  endtask

  task automatic step(string tag, bit r, bit w, bit iw, bit cw, logic [15:0] a,
                      logic [7:0] d, logic [7:0] ior);
    @(negedge clk);
    rd = r; wr = w; io_wr = iw; ctl_wr = cw; addr = a; data = d; io_rdata = ior;
    #8 check(tag);
  endtask

  initial begin
    #(20ns * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    step("R1", 0, 0, 0, 0, 16'h0000, 8'h00, 8'h00);
    step("R1", 1, 0, 1, 1, 16'hE000, 8'h00, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    #8 check("R1");
    // R2: clear run with strobes that must be ignored
    for (int i = 0; m_busy && i < 70000; i++)
      step("R2", i[0], i[1], (i % 97) == 5, (i % 193) == 5, 16'(i * 37), 8'(i), 8'h33);
    step("R2", 0, 0, 0, 0, 16'h0000, 8'h00, 8'h33);
    // R3: overlay reads hit ROM in all windows
    for (int w = 0; w < 8; w++) step("R3", 1, 0, 0, 0, 16'(w * 8192 + 16'h0123 + w), 8'h00, 8'h00);
    step("R6", 0, 0, 0, 0, 16'h0000, 8'h00, 8'h5A);
    // R4: overlay writes reach RAM
    for (int w = 0; w < 8; w++) step("R4", 0, 1, 0, 0, 16'(w * 8192 + 16'h0042), 8'(8'hA0 + w), 8'h00);
    // R9: control strobe without io write is ignored
    step("R9", 0, 0, 0, 1, 16'h0000, 8'h00, 8'h00);
    step("R9", 1, 0, 0, 0, 16'h2000, 8'h00, 8'h00);
    // R5: plain io write ends overlay
    step("R5", 0, 0, 1, 0, 16'h0000, 8'h00, 8'h00);
    step("R5", 1, 0, 0, 0, 16'h0100, 8'h00, 8'h00);
    step("R6", 0, 0, 0, 0, 16'h0000, 8'h00, 8'h5A);
    // R7: low windows read RAM linearly
    for (int w = 0; w < 7; w++) step("R7", 1, 0, 0, 0, 16'(w * 8192 + 16'h1FFF), 8'h00, 8'h00);
    step("R8", 1, 0, 0, 0, 16'hE000, 8'h00, 8'h00);
    step("R8", 1, 0, 0, 0, 16'hFFFF, 8'h00, 8'h00);
    // R9 / R8: flag toggling
    step("R9", 0, 0, 1, 1, 16'h0000, 8'hFE, 8'h00);
    step("R8", 1, 0, 0, 0, 16'hE123, 8'h00, 8'h00);
    step("R10", 0, 1, 0, 0, 16'hF000, 8'h77, 8'h00);
    step("R9", 0, 0, 1, 1, 16'h0000, 8'h01, 8'h00);
    step("R8", 1, 0, 0, 0, 16'hE123, 8'h00, 8'h00);
    step("R10", 0, 1, 0, 0, 16'hF000, 8'h66, 8'h00);
    step("R9", 0, 0, 0, 1, 16'h0000, 8'h00, 8'h00);
    step("R9", 1, 0, 0, 0, 16'hFFF0, 8'h00, 8'h00);
    // R10: write wins over simultaneous read
    step("R10", 1, 1, 0, 0, 16'hE555, 8'h12, 8'h00);
    // R11: idle
    step("R11", 0, 0, 0, 0, 16'hBEEF, 8'h99, 8'h00);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule